// File: doc/BRIEF.md
# Serial I/Q Word Formatter

This block takes one parallel pair of in-phase (I) and quadrature (Q) result words per input strobe and sends them out as serial bit streams. The receiver is a processor-style serial port. The block drives a serial bit clock, a word strobe and two data lines. It reports busy while a transfer is in progress. An input pair that arrives during a transfer is refused and flagged as an overrun.

Three output arrangements are available. In the dual-line arrangement, I and Q leave on their own lines at the same time. In the sequential arrangement, the whole I word and then the whole Q word leave on the I line. In the real arrangement, one word per sample leaves on the I line, taken in turn from I, -Q, -I and Q, which shifts the spectrum by a quarter of the sample rate. The word length and the serial clock ratio are set by inputs. Both are captured when a pair is accepted. Both data lines are driven back to zero once the last bit has gone out.

Top module: `sif_serial_formatter`

## Requirements
- R1: While reset is asserted and whenever no transfer is in progress, busy, ser_clk, word_strobe, ser_i, ser_q and overrun are all low.
- R2: A high in_valid sampled while busy is low starts a transfer. Busy is high from the next cycle for exactly W*L*2H cycles. W is 2 in sequential mode and 1 otherwise, L is the effective word length and H is the effective half ratio.
- R3: Each bit occupies 2H system clocks. ser_clk is low for the first H and high for the last H. The data lines and the strobe never change on the cycle where ser_clk rises. H equals half_div, and a half_div of 0 acts as 1.
- R4: The effective word length L is word_len clamped to the range 8..38. The word sent is the upper L bits of the input, most significant bit first.
- R5: With fmt_mode 0 (and also 3), I goes out on ser_i while Q goes out on ser_q over the same bit periods.
- R6: With fmt_mode 1, the I word goes out on ser_i and is followed at once by the Q word on the same line. ser_q stays low for the whole transfer.
- R7: With fmt_mode 2, one word goes out on ser_i and ser_q stays low. The word follows the cycle I, -Q, -I, Q, where negation is L-bit two's complement. The cycle starts at I after reset and advances only on accepted mode-2 pairs.
- R8: word_strobe is high for exactly the bit period of the first bit of every word, which means twice per transfer in mode 1.
- R9: After the final bit of a transfer, ser_i and ser_q return to zero.
- R10: A high in_valid sampled while busy is high makes overrun high for the following cycle. That pair is dropped, and the transfer in progress is unaffected.
- R11: fmt_mode, word_len and half_div are captured at acceptance, so changes to them during a transfer have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Offers one I/Q pair |
| in_i | input | 38 | In-phase word, left aligned |
| in_q | input | 38 | Quadrature word, left aligned |
| fmt_mode | input | 2 | 0/3 dual line, 1 sequential, 2 real |
| word_len | input | 6 | Requested bits per word |
| half_div | input | 8 | System clocks per serial clock half period |
| ser_clk | output | 1 | Serial bit clock; the receiver samples on the rising edge |
| word_strobe | output | 1 | High during the first bit of each word |
| ser_i | output | 1 | I serial data |
| ser_q | output | 1 | Q serial data |
| busy | output | 1 | Transfer in progress |
| overrun | output | 1 | One-cycle pulse for a refused pair |

## Verification
A wrong bit counter or state register shows up within one transfer: the busy length differs from W*L*2H cycles, or the strobe lands on the wrong captured bit. A wrong phase counter distorts ser_clk within the first bit period. A wrong real-mode index register stays hidden until the next real-mode word, and then every later real word carries the wrong sign or the wrong component. For that reason real-mode pairs run back to back, including after a dropped pair. A failure to clear the shifter shows at the first idle cycle as a data line left high.

// File: rtl/sif_pkg.sv
package sif_pkg;
  typedef enum logic [1:0] {
    MODE_SIM     = 2'd0,
    MODE_SEQ     = 2'd1,
    MODE_REAL    = 2'd2,
    MODE_SIM_ALT = 2'd3
  } sif_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } sif_state_e;
endpackage

// File: rtl/sif_word_prep.sv
module sif_word_prep
  import sif_pkg::*;
#(
  parameter int DATA_W  = 38,
  parameter int MIN_LEN = 8,
  parameter int LEN_W   = 6
) (
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  input  logic [1:0]        mode,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [1:0]        real_idx,
  output logic [LEN_W-1:0]  len_eff,
  output logic [DATA_W-1:0] word_a,
  output logic [DATA_W-1:0] word_b,
  output logic [DATA_W-1:0] word_hold
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(DATA_W);

  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] al_i, al_q, ng_i, ng_q;

  always_comb begin
    if (word_len < MIN_L)      len_eff = MIN_L;
    else if (word_len > MAX_L) len_eff = MAX_L;
    else                       len_eff = word_len;
  end

  // upper len_eff bits kept, lower bits zero: negating the aligned value
  // equals negating the short word in its own width
  assign keep_mask = ~({DATA_W{1'b1}} >> len_eff);
  assign al_i = in_i & keep_mask;
  assign al_q = in_q & keep_mask;
  assign ng_i = -al_i;
  assign ng_q = -al_q;

  always_comb begin
    word_a    = al_i;
    word_b    = al_q;
    word_hold = '0;
    case (sif_mode_e'(mode))
      MODE_SEQ: begin
        word_b    = '0;
        word_hold = al_q;
      end
      MODE_REAL: begin
        word_b = '0;
        case (real_idx)
          2'd0:    word_a = al_i;
          2'd1:    word_a = ng_q;
          2'd2:    word_a = ng_i;
          default: word_a = al_q;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sif_bit_timer.sv
module sif_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic [DIV_W-1:0] half_div,
  output logic             ser_clk,
  output logic             bit_end
);
  logic [DIV_W-1:0] half_q, half_d;
  logic [DIV_W:0]   phase_q, phase_d, phase_last;
  logic             sclk_q, sclk_d;

  assign phase_last = {half_q, 1'b0} - 1'b1;
  assign bit_end    = active && (phase_q == phase_last);

  always_comb begin
    half_d = half_q;
    if (start) half_d = (half_div == '0) ? DIV_W'(1) : half_div;
    if (start || bit_end) phase_d = '0;
    else if (active)      phase_d = phase_q + 1'b1;
    else                  phase_d = phase_q;
    sclk_d = active && (phase_d >= {1'b0, half_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= DIV_W'(1);
      phase_q <= '0;
      sclk_q  <= 1'b0;
    end else begin
      half_q  <= half_d;
      phase_q <= phase_d;
      sclk_q  <= sclk_d;
    end
  end

  assign ser_clk = sclk_q;
endmodule

// File: rtl/sif_ctrl.sv
module sif_ctrl
  import sif_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] len_eff,
  input  logic             bit_end,
  output logic             start,
  output logic             busy,
  output logic             word_strobe,
  output logic             overrun,
  output logic             shift_en,
  output logic             swap_en,
  output logic             clear_en,
  output logic [1:0]       real_idx,
  output logic [1:0]       mode_q
);
  sif_state_e       state_q, state_d;
  logic [LEN_W-1:0] bits_q, bits_d, len_q, len_d;
  logic [1:0]       idx_q, idx_d, mode_r, mode_d;
  logic             strobe_q, strobe_d, ovr_q, ovr_d, last_bit;

  assign busy     = (state_q != ST_IDLE);
  assign start    = in_valid && !busy;
  assign last_bit = bit_end && (bits_q == '0);
  assign swap_en  = last_bit && (state_q == ST_FIRST) && (sif_mode_e'(mode_r) == MODE_SEQ);
  assign clear_en = last_bit && !swap_en;
  assign shift_en = bit_end && !last_bit;

  always_comb begin
    state_d = state_q;
    bits_d  = bits_q;
    len_d   = len_q;
    mode_d  = mode_r;
    idx_d   = idx_q;
    if (start) begin
      state_d = ST_FIRST;
      bits_d  = len_eff - 1'b1;
      len_d   = len_eff;
      mode_d  = mode;
      if (sif_mode_e'(mode) == MODE_REAL) idx_d = idx_q + 2'd1;
    end else if (swap_en) begin
      state_d = ST_SECOND;
      bits_d  = len_q - 1'b1;
    end else if (clear_en) begin
      state_d = ST_IDLE;
    end else if (shift_en) begin
      bits_d = bits_q - 1'b1;
    end
    if (start || swap_en) strobe_d = 1'b1;
    else if (bit_end)     strobe_d = 1'b0;
    else                  strobe_d = strobe_q;
    ovr_d = in_valid && busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bits_q   <= '0;
      len_q    <= '0;
      mode_r   <= 2'd0;
      idx_q    <= 2'd0;
      strobe_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      bits_q   <= bits_d;
      len_q    <= len_d;
      mode_r   <= mode_d;
      idx_q    <= idx_d;
      strobe_q <= strobe_d;
      ovr_q    <= ovr_d;
    end
  end

  assign word_strobe = strobe_q;
  assign overrun     = ovr_q;
  assign real_idx    = idx_q;
  assign mode_q      = mode_r;
endmodule

// File: rtl/sif_shifter.sv
module sif_shifter #(
  parameter int DATA_W = 38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              swap,
  input  logic              clear,
  input  logic [DATA_W-1:0] word_a,
  input  logic [DATA_W-1:0] word_b,
  input  logic [DATA_W-1:0] word_hold,
  output logic              ser_i,
  output logic              ser_q
);
  logic [DATA_W-1:0] sh_i_q, sh_i_d, sh_q_q, sh_q_d, hold_q, hold_d;

  always_comb begin
    sh_i_d = sh_i_q;
    sh_q_d = sh_q_q;
    hold_d = hold_q;
    if (clear) begin
      sh_i_d = '0;
      sh_q_d = '0;
      hold_d = '0;
    end else if (load) begin
      sh_i_d = word_a;
      sh_q_d = word_b;
      hold_d = word_hold;
    end else if (swap) begin
      sh_i_d = hold_q;
      sh_q_d = '0;
      hold_d = '0;
    end else if (shift) begin
      sh_i_d = {sh_i_q[DATA_W-2:0], 1'b0};
      sh_q_d = {sh_q_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_i_q <= '0;
      sh_q_q <= '0;
      hold_q <= '0;
    end else begin
      sh_i_q <= sh_i_d;
      sh_q_q <= sh_q_d;
      hold_q <= hold_d;
    end
  end

  assign ser_i = sh_i_q[DATA_W-1];
  assign ser_q = sh_q_q[DATA_W-1];
endmodule

// File: rtl/sif_serial_formatter.sv
module sif_serial_formatter #(
  parameter int DATA_W  = 38,
  parameter int MIN_LEN = 8,
  parameter int DIV_W   = 8,
  parameter int LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  input  logic [1:0]        fmt_mode,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [DIV_W-1:0]  half_div,
  output logic              ser_clk,
  output logic              word_strobe,
  output logic              ser_i,
  output logic              ser_q,
  output logic              busy,
  output logic              overrun
);
  logic [LEN_W-1:0]  len_eff;
  logic [DATA_W-1:0] word_a, word_b, word_hold;
  logic [1:0]        real_idx, mode_q;
  logic              start, bit_end, shift_en, swap_en, clear_en;

  sif_word_prep #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_prep (
    .in_i(in_i), .in_q(in_q), .mode(fmt_mode), .word_len(word_len),
    .real_idx(real_idx), .len_eff(len_eff), .word_a(word_a),
    .word_b(word_b), .word_hold(word_hold)
  );

  sif_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(fmt_mode),
    .len_eff(len_eff), .bit_end(bit_end), .start(start), .busy(busy),
    .word_strobe(word_strobe), .overrun(overrun), .shift_en(shift_en),
    .swap_en(swap_en), .clear_en(clear_en), .real_idx(real_idx),
    .mode_q(mode_q)
  );

  sif_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .active(busy),
    .half_div(half_div), .ser_clk(ser_clk), .bit_end(bit_end)
  );

  sif_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .shift(shift_en),
    .swap(swap_en), .clear(clear_en), .word_a(word_a), .word_b(word_b),
    .word_hold(word_hold), .ser_i(ser_i), .ser_q(ser_q)
  );
endmodule

// File: rtl/sif_checker.sv
module sif_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       busy,
  input logic       ser_clk,
  input logic       word_strobe,
  input logic       ser_i,
  input logic       ser_q,
  input logic       overrun,
  input logic [1:0] mode_q
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !word_strobe && !ser_i && !ser_q));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> (busy && word_strobe && !ser_clk));

  p_stable_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(ser_clk)) |-> ($stable(ser_i) && $stable(ser_q) && $stable(word_strobe)));

  p_end_after_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ser_clk));

  p_q_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mode_q == 2'd1 || mode_q == 2'd2)) |-> !ser_q);

  p_strobe_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_strobe) |-> !ser_clk);

  p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy) |=> overrun);

  p_overrun_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && busy) |=> !overrun);
endmodule

bind sif_serial_formatter sif_checker u_sif_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
  .ser_clk(ser_clk), .word_strobe(word_strobe), .ser_i(ser_i),
  .ser_q(ser_q), .overrun(overrun), .mode_q(mode_q)
);

// File: tb/sif_serial_formatter_tb.sv
module sif_serial_formatter_tb_top;
  localparam int DW  = 38;
  localparam int LW  = 6;
  localparam int DVW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, in_valid;
  logic [DW-1:0] in_i, in_q;
  logic [1:0]    fmt_mode;
  logic [LW-1:0] word_len;
  logic [DVW-1:0] half_div;
  logic ser_clk, word_strobe, ser_i, ser_q, busy, overrun;

  int n_tests = 0;
  int n_fail  = 0;
  int rp      = 0;
  bit finished = 1'b0;

  sif_serial_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .fmt_mode(fmt_mode), .word_len(word_len), .half_div(half_div),
    .ser_clk(ser_clk), .word_strobe(word_strobe), .ser_i(ser_i),
    .ser_q(ser_q), .busy(busy), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string msg, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  function automatic int eff_len(input int l);
    if (l < 8) return 8;
    if (l > DW) return DW;
    return l;
  endfunction

  function automatic logic [127:0] top_bits(input logic [DW-1:0] x, input int l);
    return 128'(x >> (DW - l));
  endfunction

  function automatic logic [127:0] neg_l(input logic [127:0] w, input int l);
    return (-w) & ((128'd1 << l) - 128'd1);
  endfunction

  function automatic logic [DW-1:0] rnd_word();
    return DW'({$urandom, $urandom});
  endfunction

  task automatic xfer(input logic [1:0] m, input int len, input int hd,
                      input logic [DW-1:0] vi, input logic [DW-1:0] vq, input bit ov);
    int L, H, nw, total, ov_at, cyc, nb;
    logic [127:0] iw, qw, e_i, e_q, e_str, cap_i, cap_q, cap_s;
    bit seq_m, real_m, prev;
    string tag;
    L      = eff_len(len);
    H      = (hd == 0) ? 1 : hd;
    seq_m  = (m == 2'd1);
    real_m = (m == 2'd2);
    nw     = seq_m ? 2 : 1;
    total  = nw * L * 2 * H;
    ov_at  = ov ? 1 + int'($urandom % 32'(total - 1)) : 0;
    iw = top_bits(vi, L);
    qw = top_bits(vq, L);
    e_q = '0;
    if (seq_m) begin
      e_i = (iw << L) | qw;
      tag = "R6";
    end else if (real_m) begin
      case (rp)
        0: e_i = iw;
        1: e_i = neg_l(qw, L);
        2: e_i = neg_l(iw, L);
        default: e_i = qw;
      endcase
      rp  = (rp + 1) % 4;
      tag = "R7";
    end else begin
      e_i = iw;
      e_q = qw;
      tag = "R5";
    end
    e_str = 128'd1 | (seq_m ? (128'd1 << L) : 128'd0);

    @(negedge clk);
    fmt_mode = m; word_len = LW'(len); half_div = DVW'(hd);
    in_i = vi; in_q = vq; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    // R11: scramble configuration and data after acceptance
    fmt_mode = 2'($urandom); word_len = LW'($urandom); half_div = DVW'($urandom % 4);
    in_i = rnd_word(); in_q = rnd_word();
    cyc = 0; nb = 0; prev = 1'b0;
    cap_i = '0; cap_q = '0; cap_s = '0;
    while (busy && cyc < 6000) begin
      cyc++;
      if (!prev && ser_clk) begin
        cap_i = {cap_i[126:0], ser_i};
        cap_q = {cap_q[126:0], ser_q};
        if (word_strobe) cap_s = cap_s | (128'd1 << nb);
        nb++;
      end
      prev = ser_clk;
      if (ov && cyc == ov_at + 1) begin
        in_valid = 1'b0;
        chk(overrun == 1'b1, "R10 overrun pulse after refused pair", 128'(overrun), 128'd1);
      end
      if (ov && cyc == ov_at) in_valid = 1'b1;
      @(negedge clk);
    end
    chk(cyc == total, "R2 R3 R11 busy length in cycles", 128'(cyc), 128'(total));
    chk(nb == nw * L, "R4 bits captured on rising ser_clk", 128'(nb), 128'(nw * L));
    chk(cap_i == e_i, {tag, " R4 ser_i word content"}, cap_i, e_i);
    chk(cap_q == e_q, {tag, " ser_q content"}, cap_q, e_q);
    chk(cap_s == e_str, "R8 strobe on first bit of each word", cap_s, e_str);
    chk({ser_i, ser_q, ser_clk, word_strobe} == 4'b0, "R9 R1 lines back to zero",
        128'({ser_i, ser_q, ser_clk, word_strobe}), 128'd0);
    if (ov) begin
      @(negedge clk);
      chk(busy == 1'b0, "R10 refused pair does not start a transfer", 128'(busy), 128'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    fmt_mode = 2'd0; word_len = LW'(16); half_div = DVW'(1);
    repeat (4) @(negedge clk);
    chk({busy, ser_clk, word_strobe, ser_i, ser_q, overrun} == 6'b0, "R1 outputs low in reset",
        128'({busy, ser_clk, word_strobe, ser_i, ser_q, overrun}), 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, ser_clk, word_strobe, ser_i, ser_q, overrun} == 6'b0, "R1 idle after reset",
        128'({busy, ser_clk, word_strobe, ser_i, ser_q, overrun}), 128'd0);

    xfer(2'd0, 8, 1, rnd_word(), rnd_word(), 1'b0);          // R5 short word
    xfer(2'd0, 38, 2, rnd_word(), rnd_word(), 1'b0);         // R5 full width
    xfer(2'd1, 16, 1, rnd_word(), rnd_word(), 1'b0);         // R6
    xfer(2'd1, 38, 3, rnd_word(), rnd_word(), 1'b0);         // R6 full width
    for (int k = 0; k < 4; k++) xfer(2'd2, 12, 1, rnd_word(), rnd_word(), 1'b0); // R7 full cycle
    xfer(2'd2, 8, 1, {1'b1, {(DW-1){1'b0}}}, {1'b1, {(DW-1){1'b0}}}, 1'b0); // R7 most negative word
    xfer(2'd2, 8, 2, {1'b1, {(DW-1){1'b0}}}, rnd_word(), 1'b0);
    xfer(2'd0, 3, 1, rnd_word(), rnd_word(), 1'b0);          // R4 clamp low
    xfer(2'd1, 50, 1, rnd_word(), rnd_word(), 1'b0);         // R4 clamp high
    xfer(2'd0, 10, 0, rnd_word(), rnd_word(), 1'b0);         // R3 zero ratio
    xfer(2'd3, 9, 2, rnd_word(), rnd_word(), 1'b0);          // R5 alternate code
    xfer(2'd0, 20, 2, rnd_word(), rnd_word(), 1'b1);         // R10 during dual-line
    xfer(2'd2, 8, 1, rnd_word(), rnd_word(), 1'b1);          // R10 during real
    xfer(2'd2, 8, 1, rnd_word(), rnd_word(), 1'b0);          // R7 index not advanced by drop

    for (int n = 0; n < 40; n++) begin
      xfer(2'($urandom % 4), 8 + int'($urandom % 31), 1 + int'($urandom % 3),
           rnd_word(), rnd_word(), ($urandom % 4) == 0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule